// File: doc/BRIEF.md
# Complex Output Formatter

This block sits after the four per-carrier complex summers of a transmit datapath and places their results onto four 20-bit output ports. Two of the ports are primary outputs. The other two are shared pad ports with a separate drive-enable, so they can also act as inputs. A small set of configuration inputs picks one of eight port mappings: cascade, all-real, all-imaginary, three mixed complex/real layouts, a decimating interleaved I/Q stream with a strobe that marks real words, and a double-rate interleaved stream.

The block runs on one clock at twice the sample rate. An input pulse, `samp_ce_i`, marks the cycle that carries a new summer sample. In every mode except double-rate, the output registers load only on that pulse. In double-rate mode they load on every cycle: the real part follows the sample pulse and the imaginary part follows the idle cycle. In cascade mode the shared ports are released by deasserting the drive-enable.

Top module: `cplx_out_fmt`

## Requirements
- R1: The mode is decoded from `mode_sel_i`, `cplx_sel_i` and `dbl_sel_i` as follows. `mode_sel_i`=00 selects cascade regardless of the other bits. With `cplx_sel_i`=0, `mode_sel_i` values 01, 10 and 11 select real, imaginary and interleaved; in the 11 case, `dbl_sel_i`=1 selects double-rate interleaved instead. With `cplx_sel_i`=1, the values 01, 10 and 11 select complex layouts 1, 2 and 3.
- R2: In cascade mode, `bi_oe_o` is low and both shared ports carry zero. `pri_a_o` carries the real part of sum 0 and `pri_b_o` carries the imaginary part of sum 0.
- R3: In real mode, ports `bi_a_o`, `bi_b_o`, `pri_a_o` and `pri_b_o` carry the real parts of sums 0, 1, 2 and 3. In imaginary mode they carry the imaginary parts of the same sums. Sum k occupies bits [20k+19:20k] of `sum_re_i` and `sum_im_i`.
- R4: In complex layouts, the shared pair (`bi_a_o`, `bi_b_o`) carries either (re0, im0) as a complex pair or (re0, re1) as reals. The primary pair (`pri_a_o`, `pri_b_o`) carries either (re2, im2) or (re2, re3). Layout 1 has the complex pair on the shared ports only. Layout 2 has it on the primary ports only. Layout 3 has it on both.
- R5: In interleaved mode, each port k carries sum k. On the first sample after the mode is entered and on every second sample after that, the port loads the real part. On the samples in between, it loads the imaginary part of the preceding sample, and the current sample is dropped.
- R6: `strb_o` is high exactly while the interleaved or double-rate output word is real and `strobe_en_i` is high. In all other modes it is low.
- R7: In double-rate mode, the outputs after a sample-pulse cycle show the real parts of that sample. The outputs after the following cycle show its imaginary parts, so no sample is dropped.
- R8: Any change of the decoded mode restarts the interleave sequence, so the next interleaved word is real.
- R9: Outside double-rate mode, the outputs change only at the clock edge that samples `samp_ce_i` high. They ignore summer input changes on other cycles.
- R10: While reset is applied, all data outputs are zero, and `bi_oe_o` and `strb_o` are low.
- R11: `bi_oe_o` follows the decoded mode one clock later, independent of `samp_ce_i`. It is high in every mode except cascade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_ce_i | input | 1 | Marks the cycle carrying a new summer sample |
| mode_sel_i | input | 2 | Output mode field |
| cplx_sel_i | input | 1 | Selects the complex layouts |
| dbl_sel_i | input | 1 | Selects double-rate interleaving |
| strobe_en_i | input | 1 | Enables the real-word strobe |
| sum_re_i | input | 80 | Real parts of summers 0..3, 20 bits each |
| sum_im_i | input | 80 | Imaginary parts of summers 0..3, 20 bits each |
| bi_a_o | output | 20 | Shared port A data |
| bi_b_o | output | 20 | Shared port B data |
| pri_a_o | output | 20 | Primary port A data |
| pri_b_o | output | 20 | Primary port B data |
| bi_oe_o | output | 1 | Drive-enable for the shared ports |
| strb_o | output | 1 | Real-word strobe |

## Verification
Two events can land on the same edge: a mode change and a sample pulse. In that case the phase restart and the first interleaved load happen in one cycle. The bench applies every new configuration on the cycle that carries a sample pulse, and it checks that the first word after the change is real. It also forces a run that leaves the interleaved mode on an odd phase and later re-enters it, so a missed restart would show up as an imaginary first word. In the idle cycles the summer inputs are driven with unrelated values, so any load outside the sample pulse changes a checked port.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

  typedef enum logic [2:0] {
    OM_CASC  = 3'd0,
    OM_REAL  = 3'd1,
    OM_IMAG  = 3'd2,
    OM_ILV   = 3'd3,
    OM_ILV2X = 3'd4,
    OM_CX1   = 3'd5,
    OM_CX2   = 3'd6,
    OM_CX3   = 3'd7
  } omode_e;

  // per-lane source selection
  typedef struct packed {
    logic       zero;
    logic       use_im;
    logic [1:0] src;
  } lsel_t;

  function automatic omode_e mode_decode(input logic [1:0] msel, input logic cplx, input logic dbl);
    omode_e m;
    unique case (msel)
      2'b00:   m = OM_CASC;
      2'b01:   m = cplx ? OM_CX1 : OM_REAL;
      2'b10:   m = cplx ? OM_CX2 : OM_IMAG;
      default: m = cplx ? OM_CX3 : (dbl ? OM_ILV2X : OM_ILV);
    endcase
    return m;
  endfunction

  // lane 0: shared A, 1: shared B, 2: primary A, 3: primary B
  function automatic lsel_t lane_route(input omode_e m, input logic [1:0] lane);
    lsel_t s;
    s.zero   = 1'b0;
    s.use_im = 1'b0;
    s.src    = lane;
    unique case (m)
      OM_CASC: begin
        s.zero   = (lane < 2'd2);
        s.src    = 2'd0;
        s.use_im = (lane == 2'd3);
      end
      OM_REAL:  s.use_im = 1'b0;
      OM_IMAG:  s.use_im = 1'b1;
      OM_CX1: begin
        if (lane == 2'd1) begin s.src = 2'd0; s.use_im = 1'b1; end
      end
      OM_CX2: begin
        if (lane == 2'd3) begin s.src = 2'd2; s.use_im = 1'b1; end
      end
      OM_CX3: begin
        if (lane == 2'd1) begin s.src = 2'd0; s.use_im = 1'b1; end
        if (lane == 2'd3) begin s.src = 2'd2; s.use_im = 1'b1; end
      end
      default: s.use_im = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ofmt_rst_sync.sv
module ofmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ofmt_mode_ctl.sv
module ofmt_mode_ctl
  import ofmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_ce,
  input  logic [1:0] mode_sel,
  input  logic       cplx_sel,
  input  logic       dbl_sel,
  output omode_e     mode_cur,
  output logic       lane_ld,
  output logic       lane_cap,
  output logic       lane_use_hold,
  output logic       word_real,
  output logic       oe_q
);
  omode_e mode_q, mode_d;
  logic   ph_q, ph_d;
  logic   oe_d;
  logic   chg, eff_ph, ilv, dbl_act;

  // next-state logic
  always_comb begin
    mode_d   = mode_decode(mode_sel, cplx_sel, dbl_sel);
    chg      = (mode_d != mode_q);
    eff_ph   = chg ? 1'b0 : ph_q;
    ilv      = (mode_d == OM_ILV);
    dbl_act  = (mode_d == OM_ILV2X);

    lane_ld  = samp_ce | dbl_act;
    if (ilv) begin
      lane_use_hold = eff_ph;
      lane_cap      = samp_ce & ~eff_ph;
    end else if (dbl_act) begin
      lane_use_hold = ~samp_ce;
      lane_cap      = samp_ce;
    end else begin
      lane_use_hold = 1'b0;
      lane_cap      = 1'b0;
    end
    word_real = (ilv | dbl_act) & ~lane_use_hold;

    if (ilv && samp_ce) ph_d = ~eff_ph;
    else if (chg)       ph_d = 1'b0;
    else                ph_d = ph_q;

    oe_d     = (mode_d != OM_CASC);
    mode_cur = mode_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OM_CASC;
      ph_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ph_q   <= ph_d;
      oe_q   <= oe_d;
    end
  end
endmodule

// File: rtl/ofmt_lane.sv
module ofmt_lane
  import ofmt_pkg::*;
#(
  parameter int DW   = 20,
  parameter int NSUM = 4,
  parameter int LANE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSUM*DW-1:0] re_all,
  input  logic [NSUM*DW-1:0] im_all,
  input  lsel_t              sel,
  input  logic               ld,
  input  logic               cap,
  input  logic               use_hold,
  output logic [DW-1:0]      data_q
);
  logic [DW-1:0] hold_q, hold_d, data_d, pick;

  always_comb begin
    pick = sel.use_im ? im_all[sel.src*DW +: DW] : re_all[sel.src*DW +: DW];
    if (use_hold)      data_d = hold_q;
    else if (sel.zero) data_d = '0;
    else               data_d = pick;
    hold_d = cap ? im_all[LANE*DW +: DW] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
      if (ld) data_q <= data_d;
    end
  end
endmodule

// File: rtl/cplx_out_fmt.sv
module cplx_out_fmt
  import ofmt_pkg::*;
#(
  parameter int DW   = 20,
  parameter int NSUM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_ce_i,
  input  logic [1:0]         mode_sel_i,
  input  logic               cplx_sel_i,
  input  logic               dbl_sel_i,
  input  logic               strobe_en_i,
  input  logic [NSUM*DW-1:0] sum_re_i,
  input  logic [NSUM*DW-1:0] sum_im_i,
  output logic [DW-1:0]      bi_a_o,
  output logic [DW-1:0]      bi_b_o,
  output logic [DW-1:0]      pri_a_o,
  output logic [DW-1:0]      pri_b_o,
  output logic               bi_oe_o,
  output logic               strb_o
);
  localparam int NLANE = 4;

  logic          rst_s_n;
  omode_e        mode_cur;
  logic          lane_ld, lane_cap, lane_use_hold, word_real;
  logic          strb_q, strb_d;
  logic [DW-1:0] lane_q [NLANE];

  ofmt_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  ofmt_mode_ctl ctl_i (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .samp_ce       (samp_ce_i),
    .mode_sel      (mode_sel_i),
    .cplx_sel      (cplx_sel_i),
    .dbl_sel       (dbl_sel_i),
    .mode_cur      (mode_cur),
    .lane_ld       (lane_ld),
    .lane_cap      (lane_cap),
    .lane_use_hold (lane_use_hold),
    .word_real     (word_real),
    .oe_q          (bi_oe_o)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    lsel_t sel;
    assign sel = lane_route(mode_cur, 2'(g));
    ofmt_lane #(.DW(DW), .NSUM(NSUM), .LANE(g)) lane_i (
      .clk      (clk),
      .rst_n    (rst_s_n),
      .re_all   (sum_re_i),
      .im_all   (sum_im_i),
      .sel      (sel),
      .ld       (lane_ld),
      .cap      (lane_cap),
      .use_hold (lane_use_hold),
      .data_q   (lane_q[g])
    );
  end

  always_comb strb_d = lane_ld ? (strobe_en_i & word_real) : strb_q;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) strb_q <= 1'b0;
    else          strb_q <= strb_d;
  end

  assign bi_a_o  = lane_q[0];
  assign bi_b_o  = lane_q[1];
  assign pri_a_o = lane_q[2];
  assign pri_b_o = lane_q[3];
  assign strb_o  = strb_q;
endmodule

// File: rtl/cplx_out_fmt_chk.sv
module cplx_out_fmt_chk #(
  parameter int DW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          samp_ce_i,
  input logic [1:0]    mode_sel_i,
  input logic          cplx_sel_i,
  input logic          dbl_sel_i,
  input logic          strobe_en_i,
  input logic [DW-1:0] bi_a_o,
  input logic [DW-1:0] bi_b_o,
  input logic [DW-1:0] pri_a_o,
  input logic          bi_oe_o,
  input logic          strb_o
);
  logic dbl_sel_now;
  assign dbl_sel_now = (mode_sel_i == 2'b11) && !cplx_sel_i && dbl_sel_i;

  a_r11_no_drive_in_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel_i == 2'b00) |=> !bi_oe_o);

  a_r2_shared_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel_i == 2'b00 && samp_ce_i) |=> (bi_a_o == '0 && bi_b_o == '0));

  a_r6_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_o) |-> $past(strobe_en_i));

  a_r6_strobe_interleave_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_o) |-> ($past(mode_sel_i) == 2'b11 && !$past(cplx_sel_i)));

  a_r9_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_ce_i && !dbl_sel_now) |=> ($stable(pri_a_o) && $stable(bi_a_o)));

  a_r7_no_strobe_on_imag_half: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_sel_now && !samp_ce_i) |=> !strb_o);
endmodule

bind cplx_out_fmt cplx_out_fmt_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .samp_ce_i   (samp_ce_i),
  .mode_sel_i  (mode_sel_i),
  .cplx_sel_i  (cplx_sel_i),
  .dbl_sel_i   (dbl_sel_i),
  .strobe_en_i (strobe_en_i),
  .bi_a_o      (bi_a_o),
  .bi_b_o      (bi_b_o),
  .pri_a_o     (pri_a_o),
  .bi_oe_o     (bi_oe_o),
  .strb_o      (strb_o)
);

// File: tb/cplx_out_fmt_tb_top.sv
module cplx_out_fmt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 20;
  localparam int NSUM = 4;
  localparam int NS = 5;

  logic               clk;
  logic               rst_n;
  logic               samp_ce;
  logic [1:0]         msel;
  logic               cplx, dbl, sen;
  logic [NSUM*DW-1:0] sre, sim;
  logic [DW-1:0]      bi_a, bi_b, pri_a, pri_b;
  logic               oe, strb;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  cplx_out_fmt #(.DW(DW), .NSUM(NSUM)) dut_i (
    .clk (clk), .rst_n (rst_n), .samp_ce_i (samp_ce),
    .mode_sel_i (msel), .cplx_sel_i (cplx), .dbl_sel_i (dbl),
    .strobe_en_i (sen), .sum_re_i (sre), .sum_im_i (sim),
    .bi_a_o (bi_a), .bi_b_o (bi_b), .pri_a_o (pri_a), .pri_b_o (pri_b),
    .bi_oe_o (oe), .strb_o (strb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] rv(int n, int k);
    logic [63:0] t;
    if (n == 2 && k == 0) return '1;
    t = 64'(n) * 64'd40503 + 64'(k) * 64'd977 + 64'd11;
    return DW'(t ^ (t << 7));
  endfunction

  function automatic logic [DW-1:0] iv(int n, int k);
    logic [63:0] t;
    if (n == 2 && k == 1) return {1'b1, {(DW-1){1'b0}}};
    t = 64'(n) * 64'd71 + 64'(k) * 64'd52361 + 64'd300;
    return DW'(t ^ (t << 11));
  endfunction

  // bench mode numbers: 0 casc,1 real,2 imag,3 ilv,4 ilv2x,5 cx1,6 cx2,7 cx3 (R1)
  function automatic int bmode(logic [1:0] ms, logic cx, logic db);
    if (ms == 2'b00) return 0;
    if (cx) return 4 + int'(ms);
    if (ms == 2'b11) return db ? 4 : 3;
    return int'(ms);
  endfunction

  function automatic logic [DW-1:0] exp_static(int m, int p, int n);
    case (m)
      0: return (p == 2) ? rv(n, 0) : (p == 3) ? iv(n, 0) : '0;
      1: return rv(n, p);
      2: return iv(n, p);
      5: return (p == 1) ? iv(n, 0) : rv(n, p);
      6: return (p == 3) ? iv(n, 2) : rv(n, p);
      default: return (p == 1) ? iv(n, 0) : (p == 3) ? iv(n, 2) : rv(n, p);
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_out(int m, int n, bit late, bit en);
    string tag;
    logic [DW-1:0] e, g;
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: g = bi_a;
        1: g = bi_b;
        2: g = pri_a;
        default: g = pri_b;
      endcase
      if (m == 3) begin
        e   = (n % 2 == 0) ? rv(n, p) : iv(n - 1, p);
        tag = (n == 0) ? "R8" : "R5";
      end else if (m == 4) begin
        e   = late ? iv(n, p) : rv(n, p);
        tag = "R7";
      end else begin
        e = exp_static(m, p, n);
        if (late)      tag = "R9";
        else if (m == 0) tag = "R2";
        else if (m <= 2) tag = "R1/R3";
        else           tag = "R4";
      end
      chk(tag, $sformatf("mode%0d port%0d n%0d", m, p, n), 32'(g), 32'(e));
    end
    chk("R6", $sformatf("strobe mode%0d n%0d", m, n), 32'(strb),
        32'(en && ((m == 3 && n % 2 == 0) || (m == 4 && !late))));
    chk("R11", $sformatf("oe mode%0d", m), 32'(oe), 32'(m != 0));
  endtask

  task automatic run_mode(logic [1:0] ms, logic cx, logic db, bit en, int ns);
    int m;
    m = bmode(ms, cx, db);
    for (int n = 0; n < ns; n++) begin
      @(negedge clk);
      msel = ms; cplx = cx; dbl = db; sen = en;
      samp_ce = 1'b1;
      for (int k = 0; k < NSUM; k++) begin
        sre[k*DW +: DW] = rv(n, k);
        sim[k*DW +: DW] = iv(n, k);
      end
      @(negedge clk);
      check_out(m, n, 1'b0, en);
      samp_ce = 1'b0;
      for (int k = 0; k < NSUM; k++) begin
        sre[k*DW +: DW] = ~rv(n + 7, k);
        sim[k*DW +: DW] = ~iv(n + 9, k);
      end
      @(negedge clk);
      check_out(m, n, 1'b1, en);
    end
  endtask

  initial begin
    rst_n = 1'b0; samp_ce = 1'b0; msel = 2'b01; cplx = 1'b0; dbl = 1'b0; sen = 1'b1;
    sre = '1; sim = '1;
    repeat (3) @(negedge clk);
    chk("R10", "reset data", 32'(bi_a | bi_b | pri_a | pri_b), 32'd0);
    chk("R10", "reset oe/strobe", 32'({oe, strb}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 16; c++) begin
        run_mode(c[3:2], c[1], c[0], e[0], NS);
      end
    end

    // R8: leave interleaving on an odd phase, then come back
    run_mode(2'b11, 1'b0, 1'b0, 1'b1, 3);
    run_mode(2'b01, 1'b0, 1'b0, 1'b1, 1);
    run_mode(2'b11, 1'b0, 1'b0, 1'b1, 4);
    run_mode(2'b11, 1'b0, 1'b1, 1'b1, 2);
    run_mode(2'b11, 1'b0, 1'b0, 1'b1, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule